// File: doc/BRIEF.md
# Strap-Latched Configuration Register

This block is a 16-bit host-bridge configuration register that mixes three kinds of bit. Three read-only bits are captured from board strap pins once per power-up, when power-good rises. One of them selects the processor bus speed, one selects whether the expansion port runs as a graphics port or as dual digital-video outputs, and one selects the request-queue depth. Software can write a legacy monochrome-adapter flag and a two-bit memory-frequency select. The frequency select is shadowed: software reads back the value it wrote, but the effective frequency driven to the rest of the bridge changes only when a warm reset occurs.

Besides the register readback, the block drives the live control values that neighbouring logic needs. These are the committed memory-frequency code, the bus-speed bit, the monochrome flag for address routing and the queue depth. It also drives a disable flag for the secondary device and that device's capability next-pointer, which is forced to zero while the port is in digital-video mode. Power-good is sampled on the clock. While it is low, the whole block sits in its default state.

Top module: `strap_cfg_reg`

## Requirements
- R1: While `pwr_good` is low, `rd_data` reads 0x0C01, `mem_freq_eff` is 2'b11, and `mono_present` is 0. The strap fields hold their defaults: bus 0, port 0, queue 1.
- R2: At the first clock edge that samples `pwr_good` high after it was low, bit 12 takes `strap_bus_fast`, bit 1 takes `strap_port_gfx` and bit 0 takes `strap_q_deep`. These bits then hold until `pwr_good` falls, whatever the pins or `warm_rst` do.
- R3: A write with `wr_be[1]` set loads `wr_data[11:10]` into readback bits 11:10 when the code is 2'b10 (133 MHz) or 2'b11 (100 MHz). Codes 2'b00 and 2'b01 are reserved and leave the field unchanged.
- R4: `mem_freq_eff` changes only at a clock edge that samples `warm_rst` high. At that edge it takes the pending readback value of bits 11:10.
- R5: A write with `wr_be[0]` set loads `wr_data[5]` into bit 5, and `mono_present` follows bit 5. A warm reset clears bit 5 to 0.
- R6: Bits 15:13, 9:6 and 4:2 always read 0. A write changes nothing in a byte whose enable is low (`wr_be[0]` covers bits 7:0 and `wr_be[1]` covers bits 15:8).
- R7: `sec_dev_disable` is the inverse of bit 1. `cap_next_ptr` is `CAP_NEXT` when bit 1 is 1 and zero when bit 1 is 0.
- R8: `ioq_depth` is `IOQ_MAX` when bit 0 is 1 and 1 when bit 0 is 0. `bus_fast` equals bit 12 (0 = 400 MHz, 1 = 533 MHz).
- R9: A write is ignored in any cycle where `warm_rst` is high or `pwr_good` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Power-good; low holds defaults, rising edge captures straps |
| warm_rst | input | 1 | Synchronous warm reset; commits the frequency select |
| strap_bus_fast | input | 1 | Bus-speed strap pin |
| strap_port_gfx | input | 1 | Port-mode strap pin (1 = graphics port) |
| strap_q_deep | input | 1 | Queue-depth strap pin (1 = maximum depth) |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables for the write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Register readback |
| mem_freq_eff | output | 2 | Committed memory-frequency code |
| bus_fast | output | 1 | Captured bus-speed select |
| port_gfx | output | 1 | Captured port mode |
| mono_present | output | 1 | Monochrome-adapter present flag |
| sec_dev_disable | output | 1 | Secondary device disabled |
| cap_next_ptr | output | PTR_W | Secondary device capability next-pointer |
| ioq_depth | output | DEPTH_W | Request-queue depth in entries |

## Verification
The bench builds the block with `IOQ_MAX` = 8, `PTR_W` = 8 and `CAP_NEXT` = 0xA0. With those values, the two queue depths (1 and 8) and the live and forced-zero pointer are all distinct at the ports. Two power-good cycles with different strap pin sets reach both port modes and both depths. Warm resets arrive with a write pending and with a write in the same cycle, so shadowing and write blocking are both exercised.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

    localparam int REG_W   = 16;
    localparam int BE_W    = REG_W / 8;

    localparam int BIT_BUS  = 12;
    localparam int MF_HI    = 11;
    localparam int MF_LO    = 10;
    localparam int BIT_MONO = 5;
    localparam int BIT_PORT = 1;
    localparam int BIT_DEEP = 0;

    localparam logic [REG_W-1:0] CFG_DEFAULT = 16'h0C01;

    typedef enum logic [1:0] {
        MF_RSV_A = 2'b00,
        MF_RSV_B = 2'b01,
        MF_133   = 2'b10,
        MF_100   = 2'b11
    } mem_freq_e;

    typedef struct packed {
        logic bus_fast;
        logic port_gfx;
        logic q_deep;
    } strap_t;

    localparam strap_t STRAP_DEFAULT = '{bus_fast: 1'b0, port_gfx: 1'b0, q_deep: 1'b1};

    function automatic logic mf_code_ok(input logic [1:0] code);
        return (code == MF_133) || (code == MF_100);
    endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import strap_cfg_pkg::*;
(
    input  logic   clk,
    input  logic   pwr_good,
    input  strap_t pins,
    output strap_t straps
);

    typedef struct packed {
        logic   armed;
        strap_t held;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pwr_good) begin
            st_d.armed = 1'b0;
            st_d.held  = STRAP_DEFAULT;
        end else if (!st_q.armed) begin
            st_d.armed = 1'b1;
            st_d.held  = pins;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign straps = st_q.held;

endmodule

// File: rtl/rw_fields.sv
module rw_fields
    import strap_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            pwr_good,
    input  logic            warm_rst,
    input  logic            wr_en,
    input  logic [BE_W-1:0] wr_be,
    input  logic [1:0]      wr_code,
    input  logic            wr_mono,
    output mem_freq_e       mf_pend,
    output mem_freq_e       mf_eff,
    output logic            mono
);

    typedef struct packed {
        mem_freq_e pend;
        mem_freq_e eff;
        logic      mono;
    } rw_st_t;

    rw_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pwr_good) begin
            st_d.pend = MF_100;
            st_d.eff  = MF_100;
            st_d.mono = 1'b0;
        end else if (warm_rst) begin
            st_d.eff  = st_q.pend;
            st_d.mono = 1'b0;
        end else if (wr_en) begin
            if (wr_be[1] && mf_code_ok(wr_code)) begin
                st_d.pend = mem_freq_e'(wr_code);
            end
            if (wr_be[0]) begin
                st_d.mono = wr_mono;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mf_pend = st_q.pend;
    assign mf_eff  = st_q.eff;
    assign mono    = st_q.mono;

endmodule

// File: rtl/cfg_view.sv
module cfg_view
    import strap_cfg_pkg::*;
#(
    parameter int               IOQ_MAX  = 8,
    parameter int               PTR_W    = 8,
    parameter logic [PTR_W-1:0] CAP_NEXT = 8'hA0,
    parameter int               DEPTH_W  = 4
) (
    input  strap_t             straps,
    input  mem_freq_e          mf_pend,
    input  logic               mono,
    output logic [REG_W-1:0]   rd_data,
    output logic               sec_dev_disable,
    output logic [PTR_W-1:0]   cap_next_ptr,
    output logic [DEPTH_W-1:0] ioq_depth
);

    always_comb begin
        rd_data              = '0;
        rd_data[BIT_BUS]     = straps.bus_fast;
        rd_data[MF_HI:MF_LO] = mf_pend;
        rd_data[BIT_MONO]    = mono;
        rd_data[BIT_PORT]    = straps.port_gfx;
        rd_data[BIT_DEEP]    = straps.q_deep;
    end

    always_comb begin
        sec_dev_disable = !straps.port_gfx;
        cap_next_ptr    = straps.port_gfx ? CAP_NEXT : '0;
        ioq_depth       = straps.q_deep ? DEPTH_W'(IOQ_MAX) : DEPTH_W'(1);
    end

endmodule

// File: rtl/strap_cfg_reg.sv
module strap_cfg_reg
    import strap_cfg_pkg::*;
#(
    parameter int               IOQ_MAX  = 8,
    parameter int               PTR_W    = 8,
    parameter logic [PTR_W-1:0] CAP_NEXT = 8'hA0,
    localparam int              DEPTH_W  = $clog2(IOQ_MAX + 1)
) (
    input  logic               clk,
    input  logic               pwr_good,
    input  logic               warm_rst,
    input  logic               strap_bus_fast,
    input  logic               strap_port_gfx,
    input  logic               strap_q_deep,
    input  logic               wr_en,
    input  logic [1:0]         wr_be,
    input  logic [15:0]        wr_data,
    output logic [15:0]        rd_data,
    output logic [1:0]         mem_freq_eff,
    output logic               bus_fast,
    output logic               port_gfx,
    output logic               mono_present,
    output logic               sec_dev_disable,
    output logic [PTR_W-1:0]   cap_next_ptr,
    output logic [DEPTH_W-1:0] ioq_depth
);

    strap_t    pins;
    strap_t    straps;
    mem_freq_e mf_pend;
    mem_freq_e mf_eff;
    logic      mono;

    // Write data outside the two writable fields has no destination.
    logic      unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[15:12], wr_data[9:6], wr_data[4:0]};

    assign pins = '{bus_fast: strap_bus_fast, port_gfx: strap_port_gfx, q_deep: strap_q_deep};

    strap_latch u_latch (
        .clk      (clk),
        .pwr_good (pwr_good),
        .pins     (pins),
        .straps   (straps)
    );

    rw_fields u_rw (
        .clk      (clk),
        .pwr_good (pwr_good),
        .warm_rst (warm_rst),
        .wr_en    (wr_en),
        .wr_be    (wr_be),
        .wr_code  (wr_data[MF_HI:MF_LO]),
        .wr_mono  (wr_data[BIT_MONO]),
        .mf_pend  (mf_pend),
        .mf_eff   (mf_eff),
        .mono     (mono)
    );

    cfg_view #(
        .IOQ_MAX  (IOQ_MAX),
        .PTR_W    (PTR_W),
        .CAP_NEXT (CAP_NEXT),
        .DEPTH_W  (DEPTH_W)
    ) u_view (
        .straps          (straps),
        .mf_pend         (mf_pend),
        .mono            (mono),
        .rd_data         (rd_data),
        .sec_dev_disable (sec_dev_disable),
        .cap_next_ptr    (cap_next_ptr),
        .ioq_depth       (ioq_depth)
    );

    assign mem_freq_eff = mf_eff;
    assign bus_fast     = straps.bus_fast;
    assign port_gfx     = straps.port_gfx;
    assign mono_present = mono;

endmodule

// File: rtl/strap_cfg_chk.sv
module strap_cfg_chk #(
    parameter int               IOQ_MAX  = 8,
    parameter int               PTR_W    = 8,
    parameter logic [PTR_W-1:0] CAP_NEXT = 8'hA0,
    parameter int               DEPTH_W  = 4
) (
    input logic               clk,
    input logic               pwr_good,
    input logic               warm_rst,
    input logic [15:0]        rd_data,
    input logic [1:0]         mem_freq_eff,
    input logic               bus_fast,
    input logic               port_gfx,
    input logic               mono_present,
    input logic               sec_dev_disable,
    input logic [PTR_W-1:0]   cap_next_ptr,
    input logic [DEPTH_W-1:0] ioq_depth
);

    localparam logic [15:0] RSV_MASK = 16'hE3DC;

    // R2
    strap_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        ($past(pwr_good) && $past(pwr_good, 2)) |->
            $stable({bus_fast, port_gfx, rd_data[0]}));

    // R3
    pend_code_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        rd_data[11] == 1'b1);

    // R4
    eff_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        ($past(pwr_good) && !$past(warm_rst)) |-> $stable(mem_freq_eff));

    // R4
    eff_commit_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        ($past(pwr_good) && $past(warm_rst)) |-> (mem_freq_eff == $past(rd_data[11:10])));

    // R5
    mono_warm_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        ($past(pwr_good) && $past(warm_rst)) |-> (!mono_present && !rd_data[5]));

    // R6
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (rd_data & RSV_MASK) == 16'h0000);

    // R7
    cap_zero_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        sec_dev_disable |-> (cap_next_ptr == '0));

    // R7
    cap_live_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        !sec_dev_disable |-> (cap_next_ptr == CAP_NEXT && rd_data[1]));

    // R8
    depth_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (ioq_depth == DEPTH_W'(1)) || (ioq_depth == DEPTH_W'(IOQ_MAX)));

    // R8
    bus_bit_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        bus_fast == rd_data[12]);

endmodule

bind strap_cfg_reg strap_cfg_chk #(
    .IOQ_MAX  (IOQ_MAX),
    .PTR_W    (PTR_W),
    .CAP_NEXT (CAP_NEXT),
    .DEPTH_W  (DEPTH_W)
) u_chk (
    .clk             (clk),
    .pwr_good        (pwr_good),
    .warm_rst        (warm_rst),
    .rd_data         (rd_data),
    .mem_freq_eff    (mem_freq_eff),
    .bus_fast        (bus_fast),
    .port_gfx        (port_gfx),
    .mono_present    (mono_present),
    .sec_dev_disable (sec_dev_disable),
    .cap_next_ptr    (cap_next_ptr),
    .ioq_depth       (ioq_depth)
);

// File: tb/strap_cfg_reg_tb.sv
module strap_cfg_reg_tb;

    localparam int          CLK_PERIOD = 10;
    localparam int          IOQ_MAX    = 8;
    localparam int          PTR_W      = 8;
    localparam logic [7:0]  CAP_NEXT   = 8'hA0;
    localparam int          DEPTH_W    = $clog2(IOQ_MAX + 1);

    logic clk = 1'b0;
    logic pwr_good = 1'b0, warm_rst = 1'b0;
    logic strap_bus_fast = 1'b1, strap_port_gfx = 1'b1, strap_q_deep = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;
    logic [1:0]  mem_freq_eff;
    logic bus_fast, port_gfx, mono_present, sec_dev_disable;
    logic [PTR_W-1:0]   cap_next_ptr;
    logic [DEPTH_W-1:0] ioq_depth;

    int  checks = 0;
    int  errors = 0;
    bit  model_live = 1'b0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    strap_cfg_reg #(.IOQ_MAX(IOQ_MAX), .PTR_W(PTR_W), .CAP_NEXT(CAP_NEXT)) u_dut (
        .clk(clk), .pwr_good(pwr_good), .warm_rst(warm_rst),
        .strap_bus_fast(strap_bus_fast), .strap_port_gfx(strap_port_gfx),
        .strap_q_deep(strap_q_deep), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_data(rd_data), .mem_freq_eff(mem_freq_eff), .bus_fast(bus_fast),
        .port_gfx(port_gfx), .mono_present(mono_present),
        .sec_dev_disable(sec_dev_disable), .cap_next_ptr(cap_next_ptr),
        .ioq_depth(ioq_depth)
    );

    // Behavioural reference model, advanced on each rising edge.
    logic       m_pg;
    logic       m_bus, m_port, m_deep, m_mono;
    logic [1:0] m_pend, m_eff;

    always @(posedge clk) begin
        if (!pwr_good) begin
            m_pg <= 1'b0; m_bus <= 1'b0; m_port <= 1'b0; m_deep <= 1'b1;
            m_pend <= 2'b11; m_eff <= 2'b11; m_mono <= 1'b0;
        end else begin
            m_pg <= 1'b1;
            if (m_pg !== 1'b1) begin
                m_bus <= strap_bus_fast; m_port <= strap_port_gfx; m_deep <= strap_q_deep;
            end
            if (warm_rst) begin
                m_eff  <= m_pend;
                m_mono <= 1'b0;
            end else if (wr_en) begin
                if (wr_be[1] && wr_data[11]) m_pend <= wr_data[11:10];
                if (wr_be[0]) m_mono <= wr_data[5];
            end
        end
        model_live <= 1'b1;
    end

    function automatic logic [15:0] model_rd();
        return {3'b000, m_bus, m_pend, 4'b0000, m_mono, 3'b000, m_port, m_deep};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_live && !finished) begin
            chk("R6 model readback", 32'(rd_data), 32'(model_rd()));
            chk("R4 model mem_freq_eff", 32'(mem_freq_eff), 32'(m_eff));
            chk("R5 model mono_present", 32'(mono_present), 32'(m_mono));
            chk("R7 model sec_dev_disable", 32'(sec_dev_disable), 32'(!m_port));
            chk("R7 model cap_next_ptr", 32'(cap_next_ptr), m_port ? 32'(CAP_NEXT) : 32'd0);
            chk("R8 model ioq_depth", 32'(ioq_depth), m_deep ? 32'(IOQ_MAX) : 32'd1);
            chk("R8 model bus_fast", 32'(bus_fast), 32'(m_bus));
            chk("R2 model port_gfx", 32'(port_gfx), 32'(m_port));
        end
    end

    task automatic do_write(input logic [1:0] be, input logic [15:0] data);
        wr_en = 1'b1; wr_be = be; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 reset readback", 32'(rd_data), 32'h0C01);
        chk("R1 reset mem_freq_eff", 32'(mem_freq_eff), 32'h3);

        pwr_good = 1'b1;
        @(negedge clk);
        chk("R2 strap capture", 32'(rd_data), 32'h1C02);
        chk("R8 shallow depth", 32'(ioq_depth), 32'd1);
        chk("R7 graphics pointer", 32'(cap_next_ptr), 32'hA0);

        strap_bus_fast = 1'b0; strap_port_gfx = 1'b0; strap_q_deep = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 straps held after pin change", 32'(rd_data), 32'h1C02);

        do_write(2'b11, 16'hFFFF);
        chk("R6 reserved bits after all-ones write", 32'(rd_data), 32'h1C22);
        chk("R5 mono set", 32'(mono_present), 32'd1);

        do_write(2'b10, 16'h0800);
        chk("R3 pending 133", 32'(rd_data), 32'h1822);
        chk("R4 effective unchanged", 32'(mem_freq_eff), 32'h3);

        do_write(2'b10, 16'h0400);
        chk("R3 reserved code 01 ignored", 32'(rd_data), 32'h1822);
        do_write(2'b10, 16'h0000);
        chk("R3 reserved code 00 ignored", 32'(rd_data), 32'h1822);

        do_write(2'b01, 16'h0C00);
        chk("R6 high byte untouched by low lane", 32'(rd_data), 32'h1802);
        do_write(2'b01, 16'h0020);
        chk("R5 mono set again", 32'(rd_data), 32'h1822);

        warm_rst = 1'b1;
        do_write(2'b11, 16'h0C20);
        warm_rst = 1'b0;
        chk("R9 write during warm reset ignored", 32'(rd_data), 32'h1802);
        chk("R4 commit on warm reset", 32'(mem_freq_eff), 32'h2);
        chk("R5 warm reset clears mono", 32'(mono_present), 32'd0);
        chk("R2 straps survive warm reset", 32'({bus_fast, port_gfx}), 32'h3);

        do_write(2'b10, 16'h0C00);
        chk("R4 pending 100 not yet live", 32'(mem_freq_eff), 32'h2);
        chk("R3 pending 100 readback", 32'(rd_data), 32'h1C02);
        warm_rst = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0;
        chk("R4 second commit", 32'(mem_freq_eff), 32'h3);

        pwr_good = 1'b0;
        do_write(2'b11, 16'h0820);
        chk("R9 write while power-good low ignored", 32'(rd_data), 32'h0C01);
        chk("R1 defaults after power-good falls", 32'(mem_freq_eff), 32'h3);

        strap_bus_fast = 1'b1; strap_port_gfx = 1'b0; strap_q_deep = 1'b1;
        @(negedge clk);
        pwr_good = 1'b1;
        @(negedge clk);
        chk("R2 recapture", 32'(rd_data), 32'h1C01);
        chk("R7 device disabled", 32'(sec_dev_disable), 32'd1);
        chk("R7 pointer forced zero", 32'(cap_next_ptr), 32'd0);
        chk("R8 deep queue", 32'(ioq_depth), 32'(IOQ_MAX));
        chk("R8 bus fast", 32'(bus_fast), 32'd1);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule